// File: doc/BRIEF.md
# Leading-One Base-Two Logarithm Converter

This block gives an approximate base-two logarithm of an unsigned 16-bit integer using only priority detection and shifting, with no arithmetic. The integer part of the result (the characteristic) is the index of the highest set input bit. The fractional part is made of the input bits that lie below that highest bit. They are shifted up so that they sit directly under the binary point and are used as they are, with no correction term.

A tree of 4-bit leading-one cells, joined by 2:1 multiplexers, finds the highest set bit. The detector produces that position as a one-hot word. A lookup stage encodes the one-hot word into a binary exponent. A logarithmic barrel shifter, driven by that exponent, left-justifies the input. The input sample is captured in a register. The result is captured in a second register one cycle later. A zero flag marks an all-zero input.

Top module: `log2_lod`

## Requirements
- R1: For a nonzero input, `out_int` equals the bit index (0 to 15) of the most significant 1 of `in_data`.
- R2: `out_frac` is 15 bits wide and MSB-aligned. Its bit 14 holds input bit k-1, its bit 13 holds input bit k-2, and so on, where k is the leading-one index. The fraction bits below those filled from the input are zero.
- R3: The input 29 (binary 11101) gives `out_int` = 4 and `out_frac` = 15'h6800 (binary .1101 followed by zeros), which reads as 4.8125.
- R4: An input of zero sets `out_zero` to 1 and gives `out_int` = 0 and `out_frac` = 0. Any nonzero input clears `out_zero`.
- R5: A sample that is presented with `in_valid` high at a rising edge produces its result, with `out_valid` high, after the following rising edge. `out_valid` is low for one cycle for each cycle in which `in_valid` was low.
- R6: While `out_valid` is low, `out_int`, `out_frac` and `out_zero` hold their previous values. `in_data` is ignored whenever `in_valid` is low.
- R7: While reset is active (`rst_n` low), every output is zero.
- R8: Samples presented on consecutive cycles give results on consecutive cycles, in the same order.
- R9: The extremes of the input range convert as follows. 16'hFFFF gives `out_int` = 15 and `out_frac` = 15'h7FFF. 16'h0001 gives `out_int` = 0, `out_frac` = 0 and `out_zero` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks `in_data` as a sample to convert |
| in_data | input | 16 | Unsigned operand |
| out_valid | output | 1 | Result fields are new this cycle |
| out_int | output | 4 | Characteristic: the leading-one index |
| out_frac | output | 15 | Mantissa bits, MSB-aligned, used as the fraction |
| out_zero | output | 1 | The operand was zero |

## Verification
An error in the detector tree or in its multiplexer selects picks the wrong nibble. That shows up as an `out_int` that is off by a multiple of four, and a fraction that is shifted to match. An error in a single shifter stage corrupts `out_frac` only for exponents whose shift amount uses that stage. For that reason every power of two, the all-ones word and a mixed sweep are checked bit for bit. A fault in either pipeline register shows at the ports two edges after the sample is taken: as a result that lands a cycle off, a repeated result in a back-to-back stream, or fields that change while `out_valid` is low.

// File: rtl/log2_lod.sv
module log2_lod #(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [W-1:0]         in_data,
  output logic                 out_valid,
  output logic [$clog2(W)-1:0] out_int,
  output logic [W-2:0]         out_frac,
  output logic                 out_zero
);
  localparam int EW  = $clog2(W);
  localparam int NIB = W / 4;
  localparam int LW  = $clog2(NIB);

  logic         v_q;
  logic [W-1:0] d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else begin
      v_q <= in_valid;
      if (in_valid) d_q <= in_data;
    end
  end

  logic [3:0]    cell_oh [NIB];
  logic          node_any [2*NIB];
  logic [LW-1:0] node_sel [2*NIB];

  assign node_any[0] = 1'b0;
  assign node_sel[0] = '0;

  for (genvar j = 0; j < NIB; j++) begin : g_cell
    logic [3:0] b;
    assign b = d_q[4*j +: 4];
    assign cell_oh[j] = {b[3], b[2] & ~b[3], b[1] & ~|b[3:2], b[0] & ~|b[3:1]};
    assign node_any[NIB+j] = |b;
    assign node_sel[NIB+j] = LW'(j);
  end

  for (genvar i = 1; i < NIB; i++) begin : g_tree
    assign node_any[i] = node_any[2*i+1] | node_any[2*i];
    assign node_sel[i] = node_any[2*i+1] ? node_sel[2*i+1] : node_sel[2*i];
  end

  logic [W-1:0] lead_oh;
  for (genvar j = 0; j < NIB; j++) begin : g_oh
    assign lead_oh[4*j +: 4] = (node_any[1] && node_sel[1] == LW'(j)) ? cell_oh[j] : 4'b0;
  end

  logic [EW-1:0] expo;
  always_comb begin
    expo = '0;
    for (int p = 0; p < W; p++)
      if (lead_oh[p]) expo = expo | EW'(p);
  end

  logic [EW-1:0] amt;
  logic [W-1:0]  stg [EW+1];
  assign amt    = ~expo;
  assign stg[0] = d_q;
  for (genvar s = 0; s < EW; s++) begin : g_shift
    assign stg[s+1] = amt[s] ? (stg[s] << (1 << s)) : stg[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_int   <= '0;
      out_frac  <= '0;
      out_zero  <= 1'b0;
    end else begin
      out_valid <= v_q;
      if (v_q) begin
        out_int  <= expo;
        out_frac <= stg[EW][W-2:0];
        out_zero <= ~node_any[1];
      end
    end
  end
endmodule

module log2_lod_chk #(
  parameter int W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [W-1:0]         in_data,
  input logic                 out_valid,
  input logic [$clog2(W)-1:0] out_int,
  input logic [W-2:0]         out_frac,
  input logic                 out_zero
);
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  a_r5_gap_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
  a_r4_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
    out_zero |-> (out_int == '0 && out_frac == '0));
  a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == '0) |=> ##1 out_zero);
  a_r1_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[W-1]) |=> ##1 (out_int == W-1 && !out_zero));
  a_r9_unit_input: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == 1) |=> ##1 (out_int == '0 && out_frac == '0 && !out_zero));
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable({out_int, out_frac, out_zero}));
endmodule

bind log2_lod log2_lod_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_int(out_int), .out_frac(out_frac), .out_zero(out_zero)
);

// File: tb/log2_lod_tb.sv
module log2_lod_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [3:0]  out_int;
  logic [14:0] out_frac;
  logic        out_zero;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  log2_lod u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_int(out_int), .out_frac(out_frac), .out_zero(out_zero)
  );

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic int m_int(logic [15:0] x);
    for (int k = 15; k >= 0; k--) if (x[k]) return k;
    return 0;
  endfunction

  function automatic int m_frac(logic [15:0] x);
    logic [15:0] t;
    if (x == 0) return 0;
    t = x << (15 - m_int(x));
    return int'(t[14:0]);
  endfunction

  task automatic convert(logic [15:0] x, string req);
    @(negedge clk); in_valid = 1'b1; in_data = x;
    @(negedge clk); in_valid = 1'b0; in_data = 16'hA5A5;
    @(negedge clk);
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " int"}, int'(out_int), m_int(x));
    check({req, " frac"}, int'(out_frac), m_frac(x));
    check({req, " zero"}, int'(out_zero), int'(x == 0));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R7 valid", int'(out_valid), 0);
    check("R7 fields", int'({out_int, out_frac, out_zero}), 0);
  endtask

  task automatic t_example();
    convert(16'd29, "R3");
    check("R3 int", int'(out_int), 4);
    check("R3 frac", int'(out_frac), 'h6800);
  endtask

  task automatic t_zero();
    convert(16'd0, "R4");
    check("R4 flag", int'(out_zero), 1);
    convert(16'd6, "R4 clear");
  endtask

  task automatic t_powers();
    for (int k = 0; k < 16; k++) convert(16'(1 << k), "R1 power");
  endtask

  task automatic t_extremes();
    convert(16'hFFFF, "R9 ones");
    check("R9 ones frac", int'(out_frac), 'h7FFF);
    convert(16'h0001, "R9 one");
  endtask

  task automatic t_sweep();
    logic [15:0] x = 16'h1357;
    for (int i = 0; i < 40; i++) begin
      x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]} ^ 16'(i);
      x = x >> (i % 16);
      convert(x, "R2 sweep");
    end
  endtask

  task automatic t_hold();
    convert(16'h0123, "R6 pre");
    in_data = 16'h8000;
    repeat (3) @(negedge clk);
    check("R6 valid low", int'(out_valid), 0);
    check("R6 int held", int'(out_int), 8);
    check("R6 frac held", int'(out_frac), m_frac(16'h0123));
  endtask

  task automatic t_stream();
    logic [15:0] v [6] = '{16'h0003, 16'h4000, 16'h0000, 16'h00F1, 16'h7FFF, 16'h0010};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R8 valid", int'(out_valid), 1);
        check("R8 int", int'(out_int), m_int(v[i-2]));
        check("R8 frac", int'(out_frac), m_frac(v[i-2]));
        check("R8 zero", int'(out_zero), int'(v[i-2] == 0));
      end
      in_valid = (i < 6);
      in_data = (i < 6) ? v[i] : 16'h0;
    end
    @(negedge clk);
    check("R5 gap", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_example();
    t_zero();
    t_powers();
    t_extremes();
    t_sweep();
    t_hold();
    t_stream();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule